// File: doc/BRIEF.md
# Programmable Three-Tap FIR Filter

This block is a streaming three-tap finite impulse response filter for 12-bit unsigned samples. A new sample is accepted on every clock. Each output is a weighted sum of the three most recent samples, computed at full precision, clamped to the 12-bit range and then registered. No controller or handshake is involved, and the filter produces a fresh result every cycle.

The three weights sit in registers that can be rewritten while the filter runs. A write presents a 12-bit value, a 2-bit selector and a write enable. Selector 0 weights the newest sample, selector 1 the sample before it and selector 2 the oldest. Selector 3 is a dead slot. Integration is a matter of feeding one sample per clock on `sample_i` and taking `y_o`.

Top module: `fir3_filter`

## Requirements
- R1: While `rst_ni` is low, and after it is released, the sample history, all three weights and `y_o` are zero. With all weights cleared, `y_o` stays 0 for any input.
- R2: Let x[k] be the value on `sample_i` at rising edge k. After edge k+1, `y_o` equals clamp(w0·x[k] + w1·x[k-1] + w2·x[k-2]), where w0, w1 and w2 are the weights in force at edge k+1. History before reset counts as zero.
- R3: When `coef_we_i` is 1 and `coef_sel_i` is 0, 1 or 2 at an edge, weight w0, w1 or w2 respectively takes `coef_i`. The other weights keep their values.
- R4: A write with `coef_sel_i` = 3 changes no weight.
- R5: When `coef_we_i` is 0, no weight changes, whatever `coef_sel_i` and `coef_i` hold.
- R6: A weight written at edge k is used in the result registered at edge k+1. The result registered at edge k still uses the old value.
- R7: Samples and weights are unsigned. The products and their sum are kept at full width, and any sum above 4095 gives `y_o` = 4095. Sums of 4095 or less pass through unchanged.
- R8: The filter has no enable or idle state. `y_o` is updated from the current history on every clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sample_i | input | 12 | Input sample, one per clock |
| coef_we_i | input | 1 | Weight write enable |
| coef_sel_i | input | 2 | Weight selector: 0 newest tap, 1 middle, 2 oldest, 3 unused |
| coef_i | input | 12 | Weight value to write |
| y_o | output | 12 | Registered, clamped filter output |

## Verification
Single-sample impulses with distinct weights 1, 2 and 3 show the tap order and the two-edge latency. The same impulse is repeated after a write to the dead selector and after a disabled write, so any weight those writes touched would show up in the response. A constant stream with a weight changed in the middle of it marks the exact edge at which the new weight takes effect. Full-scale values, and sums just under and just over 4095, test the clamp. A long seeded random stream with sporadic writes then compares every output against a bench model.

// File: rtl/fir3_pkg.sv
package fir3_pkg;
  localparam int unsigned NUM_TAPS = 3;
  localparam int unsigned SEL_W    = 2;
endpackage

// File: rtl/fir3_taps.sv
module fir3_taps #(
  parameter int unsigned DATA_W = 12,
  parameter int unsigned DEPTH  = 3
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic [DATA_W-1:0]             sample_i,
  output logic [DEPTH-1:0][DATA_W-1:0]  taps_o
);
  logic [DEPTH-1:0][DATA_W-1:0] taps_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) taps_q[0] <= '0;
    else         taps_q[0] <= sample_i;
  end

  for (genvar k = 1; k < DEPTH; k++) begin : g_shift
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) taps_q[k] <= '0;
      else         taps_q[k] <= taps_q[k-1];
    end
  end

  assign taps_o = taps_q;
endmodule

// File: rtl/fir3_coef_bank.sv
module fir3_coef_bank #(
  parameter int unsigned COEF_W = 12,
  parameter int unsigned DEPTH  = 3,
  parameter int unsigned SEL_W  = 2
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          we_i,
  input  logic [SEL_W-1:0]              sel_i,
  input  logic [COEF_W-1:0]             data_i,
  output logic [DEPTH-1:0][COEF_W-1:0]  coef_o
);
  logic [DEPTH-1:0][COEF_W-1:0] coef_q;
  logic [DEPTH-1:0]             hit;

  // Selector values at or above DEPTH match no slot.
  for (genvar k = 0; k < DEPTH; k++) begin : g_slot
    assign hit[k] = we_i && (sel_i == SEL_W'(k));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     coef_q[k] <= '0;
      else if (hit[k]) coef_q[k] <= data_i;
    end
  end

  assign coef_o = coef_q;
endmodule

// File: rtl/fir3_mac.sv
module fir3_mac #(
  parameter int unsigned DATA_W = 12,
  parameter int unsigned COEF_W = 12,
  parameter int unsigned DEPTH  = 3,
  parameter int unsigned OUT_W  = 12
) (
  input  logic [DEPTH-1:0][DATA_W-1:0] taps_i,
  input  logic [DEPTH-1:0][COEF_W-1:0] coef_i,
  output logic [OUT_W-1:0]             y_o
);
  localparam int unsigned PROD_W = DATA_W + COEF_W;
  localparam int unsigned SUM_W  = PROD_W + $clog2(DEPTH + 1);
  localparam logic [SUM_W-1:0] MAX_OUT = SUM_W'({OUT_W{1'b1}});

  logic [DEPTH-1:0][PROD_W-1:0] prod;
  logic [DEPTH-1:0][SUM_W-1:0]  part;

  for (genvar k = 0; k < DEPTH; k++) begin : g_mul
    assign prod[k] = PROD_W'(taps_i[k]) * PROD_W'(coef_i[k]);
  end

  assign part[0] = SUM_W'(prod[0]);
  for (genvar k = 1; k < DEPTH; k++) begin : g_add
    assign part[k] = part[k-1] + SUM_W'(prod[k]);
  end

  always_comb begin
    if (part[DEPTH-1] > MAX_OUT) y_o = {OUT_W{1'b1}};
    else                         y_o = part[DEPTH-1][OUT_W-1:0];
  end
endmodule

// File: rtl/fir3_filter.sv
module fir3_filter #(
  parameter int unsigned DATA_W = 12,
  parameter int unsigned COEF_W = 12,
  parameter int unsigned OUT_W  = 12
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic [DATA_W-1:0]          sample_i,
  input  logic                       coef_we_i,
  input  logic [fir3_pkg::SEL_W-1:0] coef_sel_i,
  input  logic [COEF_W-1:0]          coef_i,
  output logic [OUT_W-1:0]           y_o
);
  import fir3_pkg::*;

  logic [NUM_TAPS-1:0][DATA_W-1:0] taps;
  logic [NUM_TAPS-1:0][COEF_W-1:0] coefs;
  logic [OUT_W-1:0]                y_d;
  logic [OUT_W-1:0]                y_q;

  fir3_taps #(.DATA_W(DATA_W), .DEPTH(NUM_TAPS)) u_taps (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .sample_i(sample_i),
    .taps_o  (taps)
  );

  fir3_coef_bank #(.COEF_W(COEF_W), .DEPTH(NUM_TAPS), .SEL_W(SEL_W)) u_coef (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .we_i  (coef_we_i),
    .sel_i (coef_sel_i),
    .data_i(coef_i),
    .coef_o(coefs)
  );

  fir3_mac #(.DATA_W(DATA_W), .COEF_W(COEF_W), .DEPTH(NUM_TAPS), .OUT_W(OUT_W)) u_mac (
    .taps_i(taps),
    .coef_i(coefs),
    .y_o   (y_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) y_q <= '0;
    else         y_q <= y_d;
  end

  assign y_o = y_q;
endmodule

// File: rtl/fir3_filter_chk.sv
module fir3_filter_chk #(
  parameter int unsigned DATA_W = 12,
  parameter int unsigned COEF_W = 12,
  parameter int unsigned OUT_W  = 12
) (
  input logic                                          clk_i,
  input logic                                          rst_ni,
  input logic [DATA_W-1:0]                             sample_i,
  input logic                                          coef_we_i,
  input logic [fir3_pkg::SEL_W-1:0]                    coef_sel_i,
  input logic [COEF_W-1:0]                             coef_i,
  input logic [OUT_W-1:0]                              y_o,
  input logic [fir3_pkg::NUM_TAPS-1:0][DATA_W-1:0]     taps,
  input logic [fir3_pkg::NUM_TAPS-1:0][COEF_W-1:0]     coefs
);
  import fir3_pkg::*;

  logic            past_ok;
  longint unsigned acc;
  logic [OUT_W-1:0] ref_y;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) past_ok <= 1'b0;
    else         past_ok <= 1'b1;
  end

  always_comb begin
    acc = 0;
    for (int k = 0; k < NUM_TAPS; k++) acc += longint'(taps[k]) * longint'(coefs[k]);
    ref_y = (acc > longint'({OUT_W{1'b1}})) ? {OUT_W{1'b1}} : acc[OUT_W-1:0];
  end

  // R2, R7, R8
  a_r2_output_tracks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    past_ok |-> y_o == $past(ref_y));

  a_r2_newest_tap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    past_ok |-> taps[0] == $past(sample_i));

  a_r4_dead_sel: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (past_ok && coef_we_i && coef_sel_i == SEL_W'(3)) |=> $stable(coefs));

  a_r5_no_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (past_ok && !coef_we_i) |=> $stable(coefs));

  for (genvar k = 0; k < NUM_TAPS; k++) begin : g_slot
    a_r3_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (coef_we_i && coef_sel_i == SEL_W'(k)) |=> coefs[k] == $past(coef_i));
    a_r3_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (past_ok && !(coef_we_i && coef_sel_i == SEL_W'(k))) |=> $stable(coefs[k]));
  end
endmodule

bind fir3_filter fir3_filter_chk #(.DATA_W(DATA_W), .COEF_W(COEF_W), .OUT_W(OUT_W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .sample_i  (sample_i),
  .coef_we_i (coef_we_i),
  .coef_sel_i(coef_sel_i),
  .coef_i    (coef_i),
  .y_o       (y_o),
  .taps      (taps),
  .coefs     (coefs)
);

// File: tb/tb_fir3_filter.sv
module tb_fir3_filter;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:0] sample;
  logic        we;
  logic [1:0]  sel;
  logic [11:0] cval;
  logic [11:0] y;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  int unsigned m_tap [3];
  int unsigned m_coef[3];

  always #2.5 clk = ~clk;

  fir3_filter dut (
    .clk_i(clk), .rst_ni(rst_n), .sample_i(sample),
    .coef_we_i(we), .coef_sel_i(sel), .coef_i(cval), .y_o(y)
  );

  function automatic int unsigned clamp12(int unsigned v);
    return (v > 4095) ? 4095 : v;
  endfunction

  task automatic check(string tag, int unsigned act, int unsigned exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: y_o=%0d expected %0d", tag, act, exp);
    end
  endtask

  // Called at a falling edge; applies inputs for one rising edge, checks at the next falling edge.
  task automatic step(string tag, int unsigned x, bit w = 0, int unsigned s = 0, int unsigned c = 0);
    int unsigned exp;
    sample = 12'(x); we = w; sel = 2'(s); cval = 12'(c);
    exp = clamp12(m_coef[0]*m_tap[0] + m_coef[1]*m_tap[1] + m_coef[2]*m_tap[2]);
    m_tap[2] = m_tap[1]; m_tap[1] = m_tap[0]; m_tap[0] = x;
    if (w && s < 3) m_coef[s] = c;
    @(negedge clk);
    check(tag, y, exp);
  endtask

  task automatic impulse(string tag);
    step(tag, 1); step(tag, 0); step(tag, 0); step(tag, 0); step(tag, 0);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: y_o=%0d expected completion", y);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int unsigned seed_dummy;
    bit [11:0] prev_y;
    seed_dummy = $urandom(32'd20240611);
    sample = '0; we = 0; sel = '0; cval = '0;
    foreach (m_tap[k]) begin m_tap[k] = 0; m_coef[k] = 0; end
    repeat (3) @(negedge clk);
    check("R1 in reset", y, 0);
    sample = 12'd4095; @(negedge clk);
    check("R1 in reset with input", y, 0);
    rst_n = 1'b1;
    sample = '0;
    // Cleared weights: full-scale input still yields 0
    repeat (4) step("R1 cleared weights", 4095);
    repeat (3) step("R1 flush", 0);

    // Load distinct weights per slot
    step("R3 load w0", 0, 1, 0, 1);
    step("R3 load w1", 0, 1, 1, 2);
    step("R3 load w2", 0, 1, 2, 3);
    impulse("R2 impulse order");

    // Dead selector must not disturb any weight
    step("R4 dead selector", 0, 1, 3, 100);
    impulse("R4 impulse after dead write");

    // Disabled writes to every selector
    for (int s = 0; s < 4; s++) step("R5 disabled write", 0, 0, s, 77);
    impulse("R5 impulse after disabled write");

    // Mid-stream weight change, constant input
    repeat (4) step("R6 steady", 10);
    step("R6 write edge", 10, 1, 0, 5);
    step("R6 first new result", 10);
    step("R6 settled", 10);

    // Clamp boundaries
    step("R7 setup", 0, 1, 1, 0);
    step("R7 setup", 0, 1, 2, 0);
    step("R7 setup", 0, 1, 0, 1);
    repeat (4) step("R7 exact 4095", 4095);
    step("R7 setup", 0, 1, 0, 2);
    repeat (3) step("R7 4094 passes", 2047);
    repeat (3) step("R7 4096 clamps", 2048);
    for (int s = 0; s < 3; s++) step("R7 full weights", 4095, 1, s, 4095);
    repeat (4) step("R7 full scale", 4095);

    // Output updates every edge with alternating input
    step("R8 setup", 0, 1, 1, 0);
    step("R8 setup", 0, 1, 2, 0);
    step("R8 setup", 0, 1, 0, 1);
    step("R8 setup", 0);
    prev_y = y;
    for (int i = 0; i < 8; i++) begin
      step("R8 toggle", (i % 2) ? 7 : 300);
      checks++;
      if (i > 0 && y == prev_y) begin
        errors++;
        $display("FAIL R8 no update: y_o=%0d expected change from %0d", y, prev_y);
      end
      prev_y = y;
    end

    // Seeded random stream with sporadic writes
    for (int i = 0; i < 2000; i++) begin
      int unsigned x, c, s;
      bit w;
      x = ($urandom % 4 == 0) ? 4095 - ($urandom % 16) : $urandom % 4096;
      w = ($urandom % 5 == 0);
      s = $urandom % 4;
      c = ($urandom % 3 == 0) ? $urandom % 4 : $urandom % 4096;
      step("R2 random", x, w, s, c);
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule